// File: doc/BRIEF.md
# High-Speed / Legacy Segment Bridge Switch Controller

This block drives the three switch controls of a bridge that sits between a fast two-wire segment and a slower standard/fast-speed segment. It watches all four bus lines, passes each through a two-flop synchronizer and looks for START, STOP and the special one-byte code that announces a high-speed transfer. The code byte must begin with the bit pattern `00001` (bits 7..3, most significant first; the low three bits are don't-care), must follow a START, and must be answered by a not-acknowledge (SDA high on the ninth clock). While no such code is seen, both segments stay joined and every device talks at ordinary speed.

Once the code has been refused with a not-acknowledge, the controller cuts the data path first, then clamps the legacy data line low. It cuts the clock path when both clocks are sampled high, before the repeated START that opens the fast transfer. A STOP seen on the fast data line rejoins the clocks and releases the clamp, which gives the legacy side its own STOP. The data path is rejoined only after legacy SDA is sampled high, so every join happens while the lines it connects are high. A legacy clock held low for `HANG_NS` nanoseconds, in any state, forces the fully joined idle state at once.

Top module: `hs_bridge_ctrl`

## Requirements
- R1: After reset the outputs show the joined idle state: `scl_join_o`=1, `sda_join_o`=1, `sda_hold_low_o`=0, `hs_mode_o`=0.
- R2: A first byte after START whose bits 7..3 are not `00001` leaves the idle state in place, even when the ninth bit is a not-acknowledge.
- R3: A code byte with bits 7..3 equal to `00001` that is answered by an acknowledge (SDA low on the ninth clock) leaves the idle state in place.
- R4: A code byte answered by a not-acknowledge opens the data path 3 cycles after the falling clock that ends the ninth bit. The legacy-SDA clamp turns on one cycle later. The clamp is never on while the data path is joined.
- R5: The clock path opens only in the cycle after both fast and legacy clocks are sampled high. It stays joined while either clock is low, including while a legacy device holds its clock low for less than the hang time.
- R6: While isolated, a repeated START and data traffic on the fast segment do not change any output.
- R7: A STOP on the fast segment while isolated rejoins the clock path and releases the clamp in the same cycle, 3 cycles after fast SDA rises. The data path stays open in that cycle.
- R8: After the clamp is released, the data path rejoins 3 cycles after legacy SDA goes high. It stays open as long as legacy SDA is held low.
- R9: If legacy SCL stays low for `HANG_NS` worth of clock cycles (100 cycles at the defaults), the controller forces the joined idle state in cycle `HANG_CYC`+2 after the line falls. A shorter low period changes nothing.
- R10: With legacy SDA free to rise, the full rejoin completes 6 cycles after the STOP on fast SDA, well inside the 1.3 us bus-free time.
- R11: `hs_mode_o` is high exactly while both paths are open and the clamp is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_scl_i | input | 1 | Fast-segment clock line sample |
| hs_sda_i | input | 1 | Fast-segment data line sample |
| ls_scl_i | input | 1 | Legacy-segment clock line sample |
| ls_sda_i | input | 1 | Legacy-segment data line sample |
| scl_join_o | output | 1 | 1 = clock switch closed (segments' clocks joined) |
| sda_join_o | output | 1 | 1 = data switch closed (segments' data joined) |
| sda_hold_low_o | output | 1 | 1 = legacy SDA clamped low |
| hs_mode_o | output | 1 | 1 = bridge isolated for a high-speed transfer |

## Verification
Every transition that a line change causes shows on the outputs three rising edges later: two synchronizer stages, then the state register. The clamp follows the data cut by one more cycle. A full rejoin takes six cycles from the STOP, and a hang recovery takes `HANG_CYC`+2 cycles from the legacy clock falling. The driver stamps each expected output word with its exact due cycle, counted from the negative edge on which it changed the lines. The monitor compares the outputs 3 ns after each rising edge, only against the items due in that cycle. Entries left in the queue at the end count as failures.

// File: rtl/hs_bridge_ctrl.sv
module hs_bridge_ctrl #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int HANG_NS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_scl_i,
  input  logic hs_sda_i,
  input  logic ls_scl_i,
  input  logic ls_sda_i,
  output logic scl_join_o,
  output logic sda_join_o,
  output logic sda_hold_low_o,
  output logic hs_mode_o
);

  localparam int HANG_CYC = (CLK_HZ / 1000) * HANG_NS / 1_000_000;
  localparam int CW = $clog2(HANG_CYC + 1);
  localparam logic [CW-1:0] HANG_LAST = CW'(HANG_CYC - 1);
  localparam logic [4:0] CODE_TOP = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CODE, ST_ACK, ST_WAITLOW, ST_CUT, ST_PARK, ST_HS, ST_REJOIN
  } st_e;

  st_e st, nxt;

  logic [1:0] sy_hc, sy_hd, sy_lc, sy_ld;
  logic hc, hd, lc, ld, hc_d, hd_d;
  logic [2:0] bit_n;
  logic [6:0] sh;
  logic [CW-1:0] hang_cnt;
  logic hc_rise, hc_fall, start_c, stop_c, hang_hit, is_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_hc <= 2'b11;
      sy_hd <= 2'b11;
      sy_lc <= 2'b11;
      sy_ld <= 2'b11;
      hc_d  <= 1'b1;
      hd_d  <= 1'b1;
    end else begin
      sy_hc <= {sy_hc[0], hs_scl_i};
      sy_hd <= {sy_hd[0], hs_sda_i};
      sy_lc <= {sy_lc[0], ls_scl_i};
      sy_ld <= {sy_ld[0], ls_sda_i};
      hc_d  <= hc;
      hd_d  <= hd;
    end
  end

  assign hc = sy_hc[1];
  assign hd = sy_hd[1];
  assign lc = sy_lc[1];
  assign ld = sy_ld[1];

  assign hc_rise = hc & ~hc_d;
  assign hc_fall = ~hc & hc_d;
  assign start_c = hc & hc_d & hd_d & ~hd;
  assign stop_c  = hc & hc_d & ~hd_d & hd;
  assign is_code = ({sh, hd} >> 3) == {3'b000, CODE_TOP};
  assign hang_hit = ~lc & (hang_cnt == HANG_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hang_cnt <= '0;
    else if (lc)
      hang_cnt <= '0;
    else if (hang_cnt != HANG_LAST)
      hang_cnt <= hang_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_n <= '0;
      sh    <= '0;
    end else if (st != ST_CODE || start_c) begin
      bit_n <= '0;
    end else if (hc_rise) begin
      bit_n <= bit_n + 1'b1;
      sh    <= {sh[5:0], hd};
    end
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:    if (start_c) nxt = ST_CODE;
      ST_CODE: begin
        if (stop_c) nxt = ST_IDLE;
        else if (hc_rise && bit_n == 3'd7) nxt = is_code ? ST_ACK : ST_IDLE;
      end
      ST_ACK: begin
        if (stop_c) nxt = ST_IDLE;
        else if (start_c) nxt = ST_CODE;
        else if (hc_rise) nxt = hd ? ST_WAITLOW : ST_IDLE;
      end
      ST_WAITLOW: begin
        if (stop_c) nxt = ST_IDLE;
        else if (start_c) nxt = ST_CODE;
        else if (hc_fall) nxt = ST_CUT;
      end
      ST_CUT:     nxt = ST_PARK;
      ST_PARK:    if (hc && lc) nxt = ST_HS;
      ST_HS:      if (stop_c) nxt = ST_REJOIN;
      ST_REJOIN:  if (ld) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
    if (hang_hit) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign scl_join_o     = (st != ST_HS);
  assign sda_join_o     = (st == ST_IDLE) || (st == ST_CODE) || (st == ST_ACK) || (st == ST_WAITLOW);
  assign sda_hold_low_o = (st == ST_PARK) || (st == ST_HS);
  assign hs_mode_o      = (st == ST_HS);

endmodule

module hs_bridge_ctrl_chk #(
  parameter int CLK_HZ = 100_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic hc,
  input logic lc,
  input logic ld,
  input logic hang_hit,
  input logic scl_join,
  input logic sda_join,
  input logic hold,
  input logic hs_mode
);

  localparam int BUF_CYC = (CLK_HZ / 1000) * 1300 / 1_000_000;
  localparam int WW = $clog2(BUF_CYC + 1);
  localparam logic [WW-1:0] BUF_LIM = WW'(BUF_CYC);

  logic [WW-1:0] win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      win <= '0;
    else if (scl_join && !sda_join && !hold)
      win <= (win == BUF_LIM) ? win : win + 1'b1;
    else
      win <= '0;
  end

  AST_CLAMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) hold |-> !sda_join); // R4
  AST_SCL_CUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $fell(scl_join) |-> $past(hc && lc)); // R5
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) ($rose(scl_join) && !$past(hang_hit)) |-> (!hold && !sda_join)); // R7
  AST_SDA_JOIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ($rose(sda_join) && !$past(hang_hit)) |-> $past(ld)); // R8
  AST_HANG_IDLE: assert property (@(posedge clk) disable iff (!rst_n) hang_hit |=> (scl_join && sda_join && !hold)); // R9
  AST_REJOIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) win < BUF_LIM); // R10
  AST_HS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) hs_mode |-> (!scl_join && !sda_join && hold)); // R11

endmodule

bind hs_bridge_ctrl hs_bridge_ctrl_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .hc(hc), .lc(lc), .ld(ld), .hang_hit(hang_hit),
  .scl_join(scl_join_o), .sda_join(sda_join_o), .hold(sda_hold_low_o), .hs_mode(hs_mode_o)
);

// File: tb/hs_bridge_ctrl_bench.sv
module hs_bridge_ctrl_bench;

  localparam int HC = 100;
  localparam logic [3:0] IDLE = 4'b0110;
  localparam logic [3:0] CUT  = 4'b0100;
  localparam logic [3:0] PARK = 4'b0101;
  localparam logic [3:0] HSM  = 4'b1001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hc = 1'b1, hd = 1'b1, lc_drv = 1'b1, ld_drv = 1'b1;
  logic scl_join, sda_join, hold, hs_mode;
  logic ls_scl, ls_sda;
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { int due; logic [3:0] v; string tag; } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;

  assign ls_scl = scl_join ? (hc & lc_drv) : lc_drv;
  assign ls_sda = hold ? 1'b0 : (sda_join ? (hd & ld_drv) : ld_drv);

  hs_bridge_ctrl u_hs_bridge_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hs_scl_i(hc), .hs_sda_i(hd), .ls_scl_i(ls_scl), .ls_sda_i(ls_sda),
    .scl_join_o(scl_join), .sda_join_o(sda_join),
    .sda_hold_low_o(hold), .hs_mode_o(hs_mode)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #3;
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        checks++;
        if ({hs_mode, scl_join, sda_join, hold} !== sbq[i].v) begin
          fails++;
          $display("FAIL %s cycle %0d actual=%b expected=%b", sbq[i].tag, cyc,
                   {hs_mode, scl_join, sda_join, hold}, sbq[i].v);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic expect_at(input int dly, input logic [3:0] v, input string tag);
    exp_t e;
    e.due = cyc + dly;
    e.v = v;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    hd = 1'b1; hc = 1'b1; tick(4);
    hd = 1'b0; tick(4);
    hc = 1'b0; tick(4);
  endtask

  task automatic bit_c(input logic b);
    hd = b; tick(2);
    hc = 1'b1; tick(4);
    hc = 1'b0; tick(2);
  endtask

  task automatic byte_c(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_c(v[i]);
  endtask

  task automatic stop_c();
    hd = 1'b0; tick(2);
    hc = 1'b1; tick(4);
    hd = 1'b1; tick(4);
  endtask

  task automatic try_code(input logic [7:0] code, input logic ninth, input string tag);
    start_c();
    byte_c(code);
    hd = ninth; tick(2);
    hc = 1'b1; tick(4);
    hc = 1'b0;
    expect_at(4, IDLE, tag);
    expect_at(8, IDLE, tag);
    tick(8);
    stop_c();
  endtask

  task automatic enter_hs(input logic [7:0] code);
    start_c();
    byte_c(code);
    bit_c(1'b1);
    tick(4);
    hc = 1'b1;
    expect_at(3, HSM, "R11");
    tick(6);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    expect_at(1, IDLE, "R1");
    tick(4);

    try_code(8'hA6, 1'b1, "R2");
    try_code(8'h17, 1'b1, "R2");
    try_code(8'h0D, 1'b0, "R3");

    // Main entry with a legacy clock stretch at the join point
    start_c();
    byte_c(8'h09);
    hd = 1'b1; tick(2);
    hc = 1'b1; tick(4);
    hc = 1'b0;
    expect_at(3, CUT, "R4");
    expect_at(4, PARK, "R4");
    tick(12);
    expect_at(1, PARK, "R5");
    lc_drv = 1'b0;
    hc = 1'b1;
    expect_at(3, PARK, "R5");
    tick(10);
    expect_at(1, PARK, "R5");
    lc_drv = 1'b1;
    expect_at(2, PARK, "R5");
    expect_at(3, HSM, "R5");
    tick(6);

    // Repeated START and fast traffic
    hd = 1'b0;
    expect_at(4, HSM, "R6");
    tick(4);
    hc = 1'b0; tick(2);
    byte_c(8'h5A);
    expect_at(1, HSM, "R6");
    tick(2);

    // STOP and free rejoin
    hd = 1'b0; tick(2);
    hc = 1'b1; tick(4);
    hd = 1'b1;
    expect_at(2, HSM, "R7");
    expect_at(3, CUT, "R7");
    expect_at(5, CUT, "R8");
    expect_at(6, IDLE, "R10");
    tick(10);

    // Short legacy clock low, then STOP with legacy SDA held low
    enter_hs(8'h0E);
    lc_drv = 1'b0;
    tick(50);
    expect_at(1, HSM, "R9");
    lc_drv = 1'b1;
    tick(10);
    expect_at(1, HSM, "R9");
    ld_drv = 1'b0;
    hd = 1'b0; tick(2);
    hc = 1'b1; tick(4);
    hd = 1'b1;
    expect_at(3, CUT, "R7");
    tick(20);
    expect_at(1, CUT, "R8");
    ld_drv = 1'b1;
    expect_at(2, CUT, "R8");
    expect_at(3, IDLE, "R8");
    tick(8);

    // Hang recovery
    enter_hs(8'h0B);
    lc_drv = 1'b0;
    expect_at(HC + 1, HSM, "R9");
    expect_at(HC + 2, IDLE, "R9");
    tick(HC + 10);
    lc_drv = 1'b1;
    tick(10);
    expect_at(1, IDLE, "R9");
    tick(4);

    if (sbq.size() != 0) begin
      foreach (sbq[i]) begin
        checks++;
        fails++;
        $display("FAIL %s cycle %0d actual=none expected=%b", sbq[i].tag, sbq[i].due, sbq[i].v);
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog cycle %0d actual=running expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule